// File: doc/BRIEF.md
# Burst Column Address Generator

This block produces the sequence of column addresses for one read burst of a synchronous memory with 8-bit column addresses. A read request carries a start column together with a burst-length code and a burst-type bit. From the next cycle onward the block presents one column address per enabled clock. It stops when the programmed number of addresses has been issued, when a terminate request arrives, or when a new read replaces the burst.

Finite bursts of 2, 4 or 8 stay inside an aligned block of that size. Inside the block the order is either a wrapping increment or the start offset XORed with a running count. A full-page burst walks all columns, wraps from the top column to zero, and continues until it is terminated. An illegal length code, or full page combined with the interleaved type, starts nothing and raises an error flag.

Top module: `burst_col_gen`

## Requirements
- R1: After reset, `busy`, `col_valid`, `last` and `mode_err` are all 0.
- R2: The length code `bl_code` maps as 000=1, 001=2, 010=4, 011=8 and 111=full page. The first address appears in the cycle after the accepted read, one address advances per cycle with `cke`=1, and `busy` falls after the final address of a finite burst.
- R3: During a burst of length L (2, 4 or 8), the column bits above log2(L) equal those of the start column.
- R4: With `interleave`=0, the offset inside the block is (start offset + k) mod L for the k-th address. For example, start 6 with L=8 gives 6,7,0,1,2,3,4,5.
- R5: With `interleave`=1, the offset is start offset XOR k. For example, start 5 with L=8 gives 5,4,7,6,1,0,3,2.
- R6: A full-page burst increments through all 256 columns, wraps from 255 to 0, and runs until terminated or restarted.
- R7: With length code 000, only the start column is issued, whatever `interleave` holds.
- R8: A read accepted while a burst is running restarts at once. In the next cycle `col_out` equals the new start column, and the old sequence is abandoned.
- R9: `term` with `cke`=1 and no simultaneous read makes `busy` 0 in the next cycle. A simultaneous read takes priority.
- R10: While `cke`=0, all inputs are ignored and `col_out`, `busy`, `last` and `mode_err` hold their values.
- R11: A read with a reserved length code (100, 101, 110), or with 111 and `interleave`=1, leaves `busy` 0 and sets `mode_err` to 1. The next legal read clears `mode_err`.
- R12: `last` is 1 exactly on the final address of a finite burst and never during a full-page burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable; low freezes the block |
| rd_start | input | 1 | Read request, start a new burst |
| start_col | input | 8 | Start column of the read |
| bl_code | input | 3 | Burst-length code |
| interleave | input | 1 | Burst type: 0 sequential, 1 interleaved |
| term | input | 1 | Terminate the running burst |
| col_out | output | 8 | Current column address |
| col_valid | output | 1 | `col_out` is part of a burst |
| busy | output | 1 | A burst is in progress |
| last | output | 1 | Final address of a finite burst |
| mode_err | output | 1 | Last read had an illegal mode |

## Verification
The assertions check the following on every cycle:
- the freeze under a low clock enable;
- the drop of `busy` after a terminate;
- the restart to the new start column;
- the rejection of illegal modes;
- the single-step increment of a sequential burst;
- the fixed upper column bits inside a running burst.

Some behaviour only the bench scenarios can show, because it depends on whole sequences:
- the exact interleaved orders;
- the full-page wrap from 255 to 0;
- the length-one case with both type values;
- a burst ending after exactly its length.

These are compared against a bench model, under random mixes of starts, terminates and clock-enable gaps.

// File: rtl/burst_col_gen.sv
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             rd_start,
  input  logic [COL_W-1:0] start_col,
  input  logic [2:0]       bl_code,
  input  logic             interleave,
  input  logic             term,
  output logic [COL_W-1:0] col_out,
  output logic             col_valid,
  output logic             busy,
  output logic             last,
  output logic             mode_err
);
  localparam logic [COL_W-1:0] ALL1 = {COL_W{1'b1}};
  localparam logic [COL_W-1:0] ZERO = '0;

  logic [COL_W-1:0] base_q, cnt_q, mask_q, offs, ord;
  logic             il_q, full_q, busy_q, err_q;
  logic             legal_in;

  function automatic logic [COL_W-1:0] mask_of(input logic [2:0] c);
    case (c)
      3'd1:    mask_of = ZERO | 1;
      3'd2:    mask_of = ZERO | 3;
      3'd3:    mask_of = ZERO | 7;
      3'd7:    mask_of = ALL1;
      default: mask_of = ZERO;
    endcase
  endfunction

  assign legal_in = (bl_code <= 3'd3) || (bl_code == 3'd7 && !interleave);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      il_q   <= 1'b0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (cke) begin
      if (rd_start) begin
        base_q <= start_col;
        cnt_q  <= '0;
        mask_q <= mask_of(bl_code);
        il_q   <= interleave;
        full_q <= (bl_code == 3'd7);
        busy_q <= legal_in;
        err_q  <= !legal_in;
      end else if (term) begin
        busy_q <= 1'b0;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        else      cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign offs      = base_q & mask_q;
  assign ord       = il_q ? (offs ^ cnt_q) : ((offs + cnt_q) & mask_q);
  assign col_out   = (base_q & ~mask_q) | (ord & mask_q);
  assign busy      = busy_q;
  assign col_valid = busy_q;
  assign last      = busy_q && !full_q && (cnt_q == mask_q);
  assign mode_err  = err_q;

  // R10: frozen while the clock enable is low
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(col_out) && $stable(busy) && $stable(mode_err));

  // R9: terminate ends the burst
  p_term_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cke && term && !rd_start |=> !busy);

  // R8: restart presents the new start column
  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke && rd_start && ((bl_code <= 3'd3) || (bl_code == 3'd7 && !interleave))
    |=> busy && col_out == $past(start_col));

  // R11: illegal modes never start a burst
  p_err_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cke && rd_start && ((bl_code > 3'd3 && bl_code != 3'd7) || (bl_code == 3'd7 && interleave))
    |=> !busy && mode_err);

  // R3: upper bits fixed during a running burst
  p_block_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cke && busy && !rd_start && !term && !last
    |=> busy && ((col_out & ~mask_q) == ($past(col_out) & ~$past(mask_q))));

  // R4: sequential step by one inside the block
  p_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cke && busy && !rd_start && !term && !last && !il_q
    |=> ((($past(col_out) + 1'b1) & $past(mask_q)) == (col_out & $past(mask_q))));

  // R12: last only within a burst
  p_last_r12: assert property (@(posedge clk) disable iff (!rst_n)
    last |-> busy && col_valid);
endmodule

// File: tb/burst_col_gen_bench.sv
module burst_col_gen_bench;
  localparam int PERIOD = 10;

  logic clk = 0, rst_n = 0, cke = 1, rd_start = 0, interleave = 0, term = 0;
  logic [7:0] start_col = 0;
  logic [2:0] bl_code = 0;
  logic [7:0] col_out;
  logic col_valid, busy, last, mode_err;

  int tests = 0, fails = 0;
  bit done = 0;

  logic [7:0] m_start, m_idx;
  logic [2:0] m_code;
  logic m_il, m_busy, m_err;

  always #(PERIOD/2) clk = ~clk;

  burst_col_gen u_burst_col_gen (
    .clk(clk), .rst_n(rst_n), .cke(cke), .rd_start(rd_start),
    .start_col(start_col), .bl_code(bl_code), .interleave(interleave),
    .term(term), .col_out(col_out), .col_valid(col_valid), .busy(busy),
    .last(last), .mode_err(mode_err));

  function automatic int blen(input logic [2:0] c);
    return (c <= 3'd3) ? (1 << c) : 256;
  endfunction

  function automatic logic [7:0] exp_col(input logic [7:0] s, input logic [2:0] c,
                                         input logic il, input logic [7:0] k);
    logic [7:0] m, off, o;
    m   = 8'(blen(c) - 1);
    off = s & m;
    o   = il ? (off ^ k) : ((off + k) & m);
    return (s & ~m) | (o & m);
  endfunction

  task automatic chk(input string tag, input int act, input int expv);
    tests++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic tick();
    bit legal;
    @(posedge clk);
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_idx = 0;
    end else if (cke) begin
      if (rd_start) begin
        legal   = (bl_code <= 3'd3) || (bl_code == 3'd7 && !interleave);
        m_busy  = legal; m_err = !legal; m_idx = 0;
        m_start = start_col; m_code = bl_code; m_il = interleave;
      end else if (term) m_busy = 0;
      else if (m_busy) begin
        if (m_code != 3'd7 && int'(m_idx) == blen(m_code) - 1) m_busy = 0;
        else m_idx = m_idx + 1;
      end
    end
    #1;
    chk("R2 busy", busy, m_busy);
    chk("R11 mode_err", mode_err, m_err);
    if (m_busy) begin
      chk(m_il ? "R5/R3 col" : "R4/R3 col", col_out,
          exp_col(m_start, m_code, m_il, m_idx));
      chk("R12 last", last,
          (m_code != 3'd7 && int'(m_idx) == blen(m_code) - 1) ? 1 : 0);
    end
  endtask

  task automatic start(input logic [7:0] s, input logic [2:0] c, input logic il);
    start_col = s; bl_code = c; interleave = il; rd_start = 1;
    tick();
    rd_start = 0;
  endtask

  task automatic expect_seq(input string tag, input logic [7:0] v [8], input int n);
    for (int i = 0; i < n; i++) begin
      chk(tag, col_out, v[i]);
      tick();
    end
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] s5 [8] = '{5, 4, 7, 6, 1, 0, 3, 2};
    logic [7:0] s6 [8] = '{8'h46, 8'h47, 8'h40, 8'h41, 8'h42, 8'h43, 8'h44, 8'h45};
    logic [7:0] fp [8] = '{254, 255, 0, 1, 2, 3, 4, 5};
    logic [7:0] b;
    void'($urandom(32'd1357));
    tick(); tick();
    chk("R1 busy", busy, 0);
    chk("R1 valid", col_valid, 0);
    chk("R1 last", last, 0);
    chk("R1 err", mode_err, 0);
    rst_n = 1;
    tick();

    start(8'h05, 3'd3, 1); expect_seq("R5 interleaved", s5, 8);
    chk("R2 end", busy, 0);
    start(8'h46, 3'd3, 0); expect_seq("R4 sequential", s6, 8);
    chk("R2 end", busy, 0);
    start(8'd254, 3'd7, 0); expect_seq("R6 full page wrap", fp, 8);
    chk("R6 still busy", busy, 1);
    chk("R12 no last in full page", last, 0);
    term = 1; tick(); term = 0;
    chk("R9 term", busy, 0);
    start(8'h9B, 3'd0, 1);
    chk("R7 len1 il", col_out, 8'h9B);
    chk("R7 len1 last", last, 1);
    tick();
    chk("R7 done", busy, 0);
    start(8'h9B, 3'd0, 0);
    chk("R7 len1 seq", col_out, 8'h9B);
    start(8'h10, 3'd2, 0); tick();
    start(8'h33, 3'd1, 0);
    chk("R8 restart", col_out, 8'h33);
    b = col_out;
    cke = 0; start_col = 8'hEE; rd_start = 1; term = 1; tick(); tick();
    chk("R10 hold col", col_out, b);
    chk("R10 hold busy", busy, 1);
    cke = 1; rd_start = 0; term = 0;
    start(8'h20, 3'd5, 0);
    chk("R11 reserved busy", busy, 0);
    chk("R11 reserved err", mode_err, 1);
    start(8'h20, 3'd7, 1);
    chk("R11 fp interleaved", mode_err, 1);
    start(8'h20, 3'd2, 1);
    chk("R11 cleared", mode_err, 0);

    for (int n = 0; n < 4000; n++) begin
      cke        = ($urandom % 6) != 0;
      rd_start   = ($urandom % 12) == 0;
      term       = ($urandom % 40) == 0;
      start_col  = 8'($urandom);
      bl_code    = 3'($urandom % 8);
      interleave = 1'($urandom);
      tick();
    end
    cke = 1; rd_start = 0; term = 0;
    tick();

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule